// File: doc/BRIEF.md
# Input Capture Channel with Edge Prescaler

This block is one channel of a timer used in capture mode. A two-bit source code chooses where capture events come from: the channel's own conditioned input, the input of the neighbouring channel, or an internal trigger line. The code for "output" parks the channel so that it captures nothing. Each event pulse from the chosen source goes through a prescaler that lets through one event in every 1, 2, 4 or 8. Each event that passes copies the free-running timer count into a capture register and raises a capture flag. If a capture lands while that flag is still up, an overcapture flag is raised too.

The source code can only be changed while the channel is disabled. Disabling the channel also restarts the prescaler count and blocks captures. The internal trigger source gives events only when the trigger routing in front of the block reports a valid selection. Software or a neighbouring block clears both flags with a one-cycle pulse.

Top module: `capture_channel`

## Requirements
- R1: After reset the capture value is 0, both flags are 0 and the source code is 00 (output).
- R2: With source code 00 no event on any source line ever produces a capture.
- R3: Source code 01 captures on `ev_own`, code 10 on `ev_nbr` and code 11 on `ev_trg`; events on the other two lines are ignored.
- R4: With source code 11 and `trig_ready` low, `ev_trg` pulses produce no capture.
- R5: A write (`sel_wr` high) updates the source code to `sel_wdata` only when `chan_en` is 0; with `chan_en` high the write is dropped and the old code stays in force.
- R6: Prescaler code 00 captures on every selected event, 01 on every 2nd, 10 on every 4th and 11 on every 8th, counting from the first event after enable.
- R7: While `chan_en` is 0 the prescaler count is held at zero and no capture occurs, so after re-enabling, the next capture needs a full prescaler period.
- R8: A qualifying event in cycle n makes `cap_val` equal to the `tcount` value of cycle n and sets `cap_flag`, both visible from cycle n+1.
- R9: A capture while `cap_flag` is already 1 (and no clear in that cycle) also sets `ovr_flag`; `ovr_flag` stays set until cleared.
- R10: A `flag_clr` pulse clears both flags in the next cycle; if a capture coincides with the clear, `cap_flag` ends up 1 and `ovr_flag` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_own | input | 1 | Event pulse from the channel's own conditioned input |
| ev_nbr | input | 1 | Event pulse from the neighbouring channel's input |
| ev_trg | input | 1 | Event pulse from the internal trigger line |
| trig_ready | input | 1 | High when the trigger routing selects a valid internal source |
| tcount | input | CNT_W | Free-running timer count |
| chan_en | input | 1 | Channel enable; low restarts the prescaler and allows source writes |
| sel_wr | input | 1 | Write strobe for the source code |
| sel_wdata | input | 2 | Source code to write (00 output, 01 own, 10 neighbour, 11 trigger) |
| psc | input | 2 | Prescaler code (00 /1, 01 /2, 10 /4, 11 /8) |
| flag_clr | input | 1 | One-cycle pulse clearing both flags |
| cap_val | output | CNT_W | Latched capture value |
| cap_flag | output | 1 | Capture flag |
| ovr_flag | output | 1 | Overcapture flag |

## Verification
Every cycle the assertions check that the output code suppresses captures, that the trigger source is silent without `trig_ready`, and that the source code holds while enabled. They also check that the prescaler count sits at zero while disabled, and how the flags and the captured value follow a capture or a clear. Only the bench's scenarios show the division ratio: a sweep over every source code, every prescaler code and every event line counts which pulses produce captures. The bench also checks restart after a disable and the end-to-end effect of an ignored write.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int PSC_W = 2;
    localparam int DIV_W = (1 << PSC_W) - 1;

    typedef enum logic [1:0] {
        SRC_OUTPUT  = 2'b00,
        SRC_OWN     = 2'b01,
        SRC_NEIGHB  = 2'b10,
        SRC_TRIGGER = 2'b11
    } cap_src_e;

    // Mask of prescaler count bits: ratio 2**code, count wraps at ratio-1.
    function automatic logic [DIV_W-1:0] div_mask(input logic [PSC_W-1:0] code);
        logic [DIV_W-1:0] m;
        m = '0;
        for (int i = 0; i < DIV_W; i++) begin
            if (i < int'(code)) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/cap_src_sel.sv
module cap_src_sel
    import cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_en,
    input  logic       sel_wr,
    input  logic [1:0] sel_wdata,
    input  logic       trig_ready,
    input  logic       ev_own,
    input  logic       ev_nbr,
    input  logic       ev_trg,
    output cap_src_e   src_q,
    output logic       src_evt
);
    typedef struct packed {
        cap_src_e src;
    } sel_state_t;

    sel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_wr && !chan_en) begin
            st_d.src = cap_src_e'(sel_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{src: SRC_OUTPUT};
        else        st_q <= st_d;
    end

    assign src_q = st_q.src;

    always_comb begin
        unique case (st_q.src)
            SRC_OWN:     src_evt = ev_own;
            SRC_NEIGHB:  src_evt = ev_nbr;
            SRC_TRIGGER: src_evt = ev_trg && trig_ready;
            default:     src_evt = 1'b0;
        endcase
    end

    // R5: code cannot change while the channel is enabled
    p_sel_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |=> $stable(src_q));

    // R4: trigger source silent without a valid trigger routing
    p_trig_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == SRC_TRIGGER && !trig_ready) |-> !src_evt);
endmodule

// File: rtl/cap_prescaler.sv
module cap_prescaler
    import cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic [PSC_W-1:0] psc,
    input  logic             evt_in,
    output logic             cap_evt
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } psc_state_t;

    psc_state_t       st_d, st_q;
    logic [DIV_W-1:0] mask;
    logic             wrap;

    always_comb begin
        mask    = div_mask(psc);
        wrap    = ((st_q.cnt & mask) == mask);
        cap_evt = chan_en && evt_in && wrap;
        st_d    = st_q;
        if (!chan_en) begin
            st_d.cnt = '0;
        end else if (evt_in) begin
            st_d.cnt = wrap ? '0 : ((st_q.cnt + 1'b1) & mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: count restarts while disabled
    p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (st_q.cnt == '0));

    // R7: no capture while disabled
    p_no_cap_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |-> !cap_evt);
endmodule

// File: rtl/cap_store.sv
module cap_store #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_evt,
    input  logic [CNT_W-1:0] tcount,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             ovr_flag
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             flag;
        logic             ovr;
    } store_state_t;

    store_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flag_clr) begin
            st_d.flag = 1'b0;
            st_d.ovr  = 1'b0;
        end
        if (cap_evt) begin
            st_d.val  = tcount;
            st_d.flag = 1'b1;
            if (st_q.flag && !flag_clr) st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_val  = st_q.val;
    assign cap_flag = st_q.flag;
    assign ovr_flag = st_q.ovr;

    // R8: capture latches the count and raises the flag
    p_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_flag && cap_val == $past(tcount)));

    // R9: capture over a pending flag raises overcapture
    p_overcap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && cap_flag && !flag_clr) |=> ovr_flag);

    // R10: a lone clear drops both flags
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !cap_evt) |=> (!cap_flag && !ovr_flag));

    // R8: value holds when nothing is captured
    p_val_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> $stable(cap_val));
endmodule

// File: rtl/capture_channel.sv
module capture_channel
    import cap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_own,
    input  logic             ev_nbr,
    input  logic             ev_trg,
    input  logic             trig_ready,
    input  logic [CNT_W-1:0] tcount,
    input  logic             chan_en,
    input  logic             sel_wr,
    input  logic [1:0]       sel_wdata,
    input  logic [1:0]       psc,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             ovr_flag
);
    cap_src_e src_q;
    logic     src_evt;
    logic     cap_evt;

    cap_src_sel u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .sel_wr     (sel_wr),
        .sel_wdata  (sel_wdata),
        .trig_ready (trig_ready),
        .ev_own     (ev_own),
        .ev_nbr     (ev_nbr),
        .ev_trg     (ev_trg),
        .src_q      (src_q),
        .src_evt    (src_evt)
    );

    cap_prescaler u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .chan_en (chan_en),
        .psc     (psc),
        .evt_in  (src_evt),
        .cap_evt (cap_evt)
    );

    cap_store #(.CNT_W(CNT_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_evt  (cap_evt),
        .tcount   (tcount),
        .flag_clr (flag_clr),
        .cap_val  (cap_val),
        .cap_flag (cap_flag),
        .ovr_flag (ovr_flag)
    );

    // R2: output code never captures
    p_out_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == SRC_OUTPUT) |-> !cap_evt);
endmodule

// File: tb/tb_capture_channel.sv
module tb_capture_channel;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ev_own = 0, ev_nbr = 0, ev_trg = 0, trig_ready = 1;
    logic [CNT_W-1:0] tcount = '0;
    logic             chan_en = 0, sel_wr = 0, flag_clr = 0;
    logic [1:0]       sel_wdata = 0, psc = 0;
    logic [CNT_W-1:0] cap_val;
    logic             cap_flag, ovr_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    capture_channel #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .ev_own(ev_own), .ev_nbr(ev_nbr),
        .ev_trg(ev_trg), .trig_ready(trig_ready), .tcount(tcount),
        .chan_en(chan_en), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .psc(psc), .flag_clr(flag_clr), .cap_val(cap_val),
        .cap_flag(cap_flag), .ovr_flag(ovr_flag)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_src(logic [1:0] code);
        chan_en = 0; sel_wr = 1; sel_wdata = code;
        step();
        sel_wr = 0;
    endtask

    task automatic clear();
        flag_clr = 1; step(); flag_clr = 0;
    endtask

    // src: 0 own, 1 neighbour, 2 trigger
    task automatic fire(int src, logic [CNT_W-1:0] v);
        tcount = v;
        ev_own = (src == 0); ev_nbr = (src == 1); ev_trg = (src == 2);
        step();
        ev_own = 0; ev_nbr = 0; ev_trg = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int match, ratio;
        logic [CNT_W-1:0] v;
        repeat (3) step();
        // R1: reset state
        chk("R1 cap_val", int'(cap_val), 0);
        chk("R1 cap_flag", int'(cap_flag), 0);
        chk("R1 ovr_flag", int'(ovr_flag), 0);
        rst_n = 1;
        step();
        // R1/R2: reset source is output, nothing captures
        chan_en = 1;
        for (int s = 0; s < 3; s++) begin
            fire(s, 16'h1111);
            chk("R1 R2 no capture after reset", int'(cap_flag), 0);
        end

        // R2: explicit output code
        set_src(2'b00); chan_en = 1;
        for (int s = 0; s < 3; s++) begin
            fire(s, 16'h2222);
            chk("R2 output code quiet", int'(cap_flag), 0);
        end

        // R3 R6 R8: sweep source codes, prescaler codes and event lines
        for (int code = 1; code < 4; code++) begin
            for (int p = 0; p < 4; p++) begin
                set_src(code[1:0]);
                psc = p[1:0];
                ratio = 1 << p;
                chan_en = 1;
                clear();
                match = 0;
                for (int i = 0; i < 10; i++) begin
                    for (int s = 0; s < 3; s++) begin
                        v = CNT_W'(code * 1000 + p * 100 + i * 3 + s + 7);
                        fire(s, v);
                        if (s == code - 1) begin
                            match++;
                            if (match % ratio == 0) begin
                                chk("R6 capture on period", int'(cap_flag), 1);
                                chk("R8 captured value", int'(cap_val), int'(v));
                                clear();
                            end else begin
                                chk("R6 skipped event", int'(cap_flag), 0);
                            end
                        end else begin
                            chk("R3 other line ignored", int'(cap_flag), 0);
                        end
                        chk("R9 no overcapture in sweep", int'(ovr_flag), 0);
                    end
                end
            end
        end

        // R4: trigger source gated by trig_ready
        set_src(2'b11); psc = 0; chan_en = 1; clear();
        trig_ready = 0;
        for (int i = 0; i < 4; i++) begin
            fire(2, 16'h3333);
            chk("R4 trigger blocked", int'(cap_flag), 0);
        end
        trig_ready = 1;
        fire(2, 16'h3434);
        chk("R4 trigger allowed", int'(cap_val), 16'h3434);

        // R5: write while enabled is dropped
        set_src(2'b01); chan_en = 1; clear();
        sel_wr = 1; sel_wdata = 2'b10; step(); sel_wr = 0;
        fire(1, 16'h4444);
        chk("R5 neighbour still ignored", int'(cap_flag), 0);
        fire(0, 16'h4545);
        chk("R5 own still selected", int'(cap_val), 16'h4545);
        chk("R5 own flag", int'(cap_flag), 1);
        clear();
        // R5: write while disabled takes effect
        set_src(2'b10); chan_en = 1;
        fire(0, 16'h4646);
        chk("R5 own now ignored", int'(cap_flag), 0);
        fire(1, 16'h4747);
        chk("R5 neighbour selected", int'(cap_val), 16'h4747);
        clear();

        // R7: disable restarts prescaler (ratio 4)
        set_src(2'b01); psc = 2'b10; chan_en = 1; clear();
        fire(0, 1); fire(0, 2);
        chan_en = 0;
        fire(0, 3);
        chk("R7 no capture while disabled", int'(cap_flag), 0);
        chan_en = 1;
        fire(0, 4); fire(0, 5); fire(0, 6);
        chk("R7 restart needs full period", int'(cap_flag), 0);
        fire(0, 16'h5757);
        chk("R7 capture after full period", int'(cap_flag), 1);
        chk("R7 value", int'(cap_val), 16'h5757);

        // R9: overcapture
        psc = 0;
        fire(0, 16'h6060);
        chk("R9 overcapture set", int'(ovr_flag), 1);
        step();
        chk("R9 overcapture sticky", int'(ovr_flag), 1);

        // R10: capture coinciding with clear
        flag_clr = 1; fire(0, 16'h7070); flag_clr = 0;
        chk("R10 coincident cap_flag", int'(cap_flag), 1);
        chk("R10 coincident ovr_flag", int'(ovr_flag), 0);
        chk("R10 coincident value", int'(cap_val), 16'h7070);
        fire(0, 16'h7171);
        chk("R10 ovr after next capture", int'(ovr_flag), 1);
        clear();
        chk("R10 clear cap_flag", int'(cap_flag), 0);
        chk("R10 clear ovr_flag", int'(ovr_flag), 0);
        chk("R10 value kept", int'(cap_val), 16'h7171);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule